// File: doc/BRIEF.md
# Paged virtual address translator

This block turns 32-bit virtual addresses into physical addresses for one memory port. Memory is divided into 4096-byte pages. The low 12 bits of an address pass through unchanged. The upper 20 bits, the virtual page number, are looked up in a 64-slot translation cache. Every slot is compared in parallel, so no slot is selected by index. On a hit the answer comes back in the cycle after the request is taken. On a miss the block issues one read on its memory port to fetch a 32-bit page table entry, places the entry in the cache and then answers.

Two table base values are supplied, one for user code and one for the kernel, and a mode flag chooses between them. The table is a flat array indexed by page number. A flush pulse empties the whole cache, and software raises it whenever the address space changes. Each entry carries a writable bit. A write to a page that is present but read-only ends in a protection fault instead of a completed translation, which lets system software build copy-on-write.

The requester raises `req_valid` with a stable address, write flag and mode, and holds them until `resp_done` or `resp_fault` pulses. It may then drop the request or present the next one.

Top module: `vpage_xlate`

## Requirements
- R1: A completed translation returns `resp_paddr` with bits 31:12 equal to the entry's page frame and bits 11:0 equal to `req_vaddr[11:0]`.
- R2: A request whose page number is cached issues no memory read and pulses its response in the cycle after it is accepted.
- R3: A request that misses issues exactly one memory read at address base + page number × 4. The base is `kern_base` when `kern_mode` is 1 and `user_base` when it is 0, and the sum wraps at 32 bits.
- R4: A fetched entry has its frame in bits 31:12, the writable flag in bit 1 and the present flag in bit 0. An entry with bit 0 clear returns fault code 2'b01 and is not cached, so a repeat of the same request misses again.
- R5: A write to a page whose writable flag is 0 returns fault code 2'b10 and no `resp_done`, whether the page hits or misses. A read of that page completes normally, and the entry stays cached after the fault.
- R6: A one-cycle `flush` pulse invalidates every cached mapping, so any request accepted after it misses.
- R7: A fetched present entry goes into the lowest-numbered empty slot. When all 64 slots are full, it replaces the slot named by a round-robin pointer. After reset the pointer starts at slot 0 and moves on by one with each replacement.
- R8: `resp_done` and `resp_fault` never rise together, and each is a one-cycle pulse. `resp_fault_code` is nonzero exactly when a fault is reported. `mem_rd_en` is a one-cycle pulse for each miss.
- R9: After reset every output is low and the cache is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Translation request, held until a response |
| req_vaddr | input | 32 | Virtual address |
| req_write | input | 1 | Access is a write |
| kern_mode | input | 1 | 1 selects the kernel table base, 0 the user base |
| user_base | input | 32 | Byte address of the user page table |
| kern_base | input | 32 | Byte address of the kernel page table |
| flush | input | 1 | Invalidate all cached mappings |
| mem_rd_en | output | 1 | Table entry read strobe |
| mem_rd_addr | output | 32 | Byte address of the table entry |
| mem_rd_valid | input | 1 | Read data valid, no earlier than the cycle after the strobe |
| mem_rd_data | input | 32 | Table entry returned by memory |
| resp_done | output | 1 | Translation completed |
| resp_fault | output | 1 | Translation faulted |
| resp_fault_code | output | 2 | 01 not present, 10 write to read-only page |
| resp_paddr | output | 32 | Physical address, valid with `resp_done` |

## Verification
Directed sequences come first. They separate a first touch from a repeat (read count and latency tell miss from hit), a read from a write on a read-only page, an absent entry from a present one, and the same page before and after a flush and a mode change. A fill of 65 distinct present pages then shows which slot is evicted: the second page must still hit and the first must miss. Random traffic over a pool of 80 pages is larger than the cache. Mixed writes, rare flushes and mode switches then exercise eviction, refill and protection together against a reference model of slots and pointer.

// File: rtl/vpage_xlate_pkg.sv
// Shared types for the page translator.
// Assumes a single outstanding request at a time.
package vpage_xlate_pkg;

    typedef enum logic [1:0] {
        FLT_NONE   = 2'b00,
        FLT_ABSENT = 2'b01,
        FLT_WPROT  = 2'b10
    } flt_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_WAIT,
        ST_RESP
    } xl_state_e;

    localparam int PTE_PRESENT_BIT  = 0;
    localparam int PTE_WRITABLE_BIT = 1;

endpackage

// File: rtl/vpage_victim.sv
// Slot chooser for cache fills: lowest empty slot, else round-robin pointer.
// Assumes adv is raised once per fill; the pointer moves only when the cache is full.
module vpage_victim #(
    parameter int ENTRIES = 64,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ENTRIES-1:0] vld,
    input  logic               adv,
    output logic [IDX_W-1:0]   slot
);

    logic [IDX_W-1:0] rr_q;
    logic [IDX_W-1:0] free_idx;
    logic             full;

    // Priority search for the lowest-numbered empty slot.
    always_comb begin
        free_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!vld[i]) free_idx = IDX_W'(i);
        end
    end

    assign full = &vld;
    assign slot = full ? rr_q : free_idx;

    // Round-robin pointer, advanced by each replacement of a full cache.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rr_q <= '0;
        end else if (adv && full) begin
            rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
        end
    end

    p_free_slot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !full) |-> !vld[slot]);

endmodule

// File: rtl/vpage_tcache.sv
// Fully associative translation cache: page number -> frame + writable flag.
// Assumes fills only follow a miss, so at most one slot ever matches.
module vpage_tcache #(
    parameter int ENTRIES = 64,
    parameter int VPN_W   = 20,
    parameter int PPN_W   = 20,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             hit,
    output logic [PPN_W-1:0] hit_ppn,
    output logic             hit_wr,
    input  logic             fill_en,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PPN_W-1:0] fill_ppn,
    input  logic             fill_wr
);

    logic [ENTRIES-1:0] vld_q;
    logic [VPN_W-1:0]   tag_q [ENTRIES];
    logic [PPN_W-1:0]   ppn_q [ENTRIES];
    logic [ENTRIES-1:0] wr_q;
    logic [ENTRIES-1:0] match;
    logic [IDX_W-1:0]   slot;

    // One comparator per slot, all evaluated in parallel.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = vld_q[g] && (tag_q[g] == lk_vpn);
    end

    // OR-reduce the matching slot's payload onto the hit outputs.
    always_comb begin
        hit_ppn = '0;
        hit_wr  = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match[i]) begin
                hit_ppn = hit_ppn | ppn_q[i];
                hit_wr  = hit_wr | wr_q[i];
            end
        end
    end
    assign hit = |match;

    vpage_victim #(.ENTRIES(ENTRIES)) victim_i (
        .clk  (clk),
        .rst_n(rst_n),
        .vld  (vld_q),
        .adv  (fill_en && !flush),
        .slot (slot)
    );

    // Valid bits: cleared by reset or flush; flush wins over a same-cycle fill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else if (flush) begin
            vld_q <= '0;
        end else if (fill_en) begin
            vld_q[slot] <= 1'b1;
        end
    end

    // Slot payload written on fill; no reset needed behind the valid bits.
    always_ff @(posedge clk) begin
        if (fill_en && !flush) begin
            tag_q[slot] <= fill_vpn;
            ppn_q[slot] <= fill_ppn;
            wr_q[slot]  <= fill_wr;
        end
    end

    p_single_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));
    p_flush_empties_r6: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (vld_q == '0));

endmodule

// File: rtl/vpage_ctrl.sv
// Request sequencer: hit response, table fetch on miss, protection check, fill.
// Assumes the requester holds its inputs until a response and memory answers
// no earlier than the cycle after mem_rd_en.
module vpage_ctrl
    import vpage_xlate_pkg::*;
#(
    parameter int VA_W      = 32,
    parameter int PAGE_BITS = 12,
    localparam int VPN_W    = VA_W - PAGE_BITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic             req_write,
    input  logic             kern_mode,
    input  logic [VA_W-1:0]  user_base,
    input  logic [VA_W-1:0]  kern_base,
    input  logic             hit,
    input  logic [VPN_W-1:0] hit_ppn,
    input  logic             hit_wr,
    output logic             fill_en,
    output logic [VPN_W-1:0] fill_vpn,
    output logic [VPN_W-1:0] fill_ppn,
    output logic             fill_wr,
    output logic             mem_rd_en,
    output logic [VA_W-1:0]  mem_rd_addr,
    input  logic             mem_rd_valid,
    input  logic [VA_W-1:0]  mem_rd_data,
    output logic             resp_done,
    output logic             resp_fault,
    output logic [1:0]       resp_fault_code,
    output logic [VA_W-1:0]  resp_paddr
);

    localparam int PAD_W = PAGE_BITS - 2;

    xl_state_e            st_q;
    logic [VPN_W-1:0]     vpn_q;
    logic [PAGE_BITS-1:0] off_q;
    logic                 wr_q;
    logic [VA_W-1:0]      addr_q;
    logic                 pte_present;
    logic                 pte_wr;

    assign pte_present = mem_rd_data[PTE_PRESENT_BIT];
    assign pte_wr      = mem_rd_data[PTE_WRITABLE_BIT];

    // Fill the cache when a present entry arrives.
    always_comb begin
        fill_en  = (st_q == ST_WAIT) && mem_rd_valid && pte_present;
        fill_vpn = vpn_q;
        fill_ppn = mem_rd_data[VA_W-1:PAGE_BITS];
        fill_wr  = pte_wr;
    end

    assign mem_rd_en   = (st_q == ST_FETCH);
    assign mem_rd_addr = addr_q;

    // State machine and registered response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q            <= ST_IDLE;
            vpn_q           <= '0;
            off_q           <= '0;
            wr_q            <= 1'b0;
            addr_q          <= '0;
            resp_done       <= 1'b0;
            resp_fault      <= 1'b0;
            resp_fault_code <= FLT_NONE;
            resp_paddr      <= '0;
        end else begin
            resp_done       <= 1'b0;
            resp_fault      <= 1'b0;
            resp_fault_code <= FLT_NONE;
            case (st_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        if (hit) begin
                            st_q <= ST_RESP;
                            if (req_write && !hit_wr) begin
                                resp_fault      <= 1'b1;
                                resp_fault_code <= FLT_WPROT;
                            end else begin
                                resp_done  <= 1'b1;
                                resp_paddr <= {hit_ppn, req_vaddr[PAGE_BITS-1:0]};
                            end
                        end else begin
                            st_q   <= ST_FETCH;
                            vpn_q  <= req_vaddr[VA_W-1:PAGE_BITS];
                            off_q  <= req_vaddr[PAGE_BITS-1:0];
                            wr_q   <= req_write;
                            addr_q <= (kern_mode ? kern_base : user_base)
                                      + {{PAD_W{1'b0}}, req_vaddr[VA_W-1:PAGE_BITS], 2'b00};
                        end
                    end
                end
                ST_FETCH: st_q <= ST_WAIT;
                ST_WAIT: begin
                    if (mem_rd_valid) begin
                        st_q <= ST_RESP;
                        if (!pte_present) begin
                            resp_fault      <= 1'b1;
                            resp_fault_code <= FLT_ABSENT;
                        end else if (wr_q && !pte_wr) begin
                            resp_fault      <= 1'b1;
                            resp_fault_code <= FLT_WPROT;
                        end else begin
                            resp_done  <= 1'b1;
                            resp_paddr <= {mem_rd_data[VA_W-1:PAGE_BITS], off_q};
                        end
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    p_one_outcome_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(resp_done && resp_fault));
    p_resp_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_done || resp_fault) |=> !(resp_done || resp_fault));
    p_rd_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> !mem_rd_en);
    p_code_fault_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_fault_code != FLT_NONE) == resp_fault);
    p_absent_nofill_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_fault && resp_fault_code == FLT_ABSENT) |-> $past(!fill_en));

endmodule

// File: rtl/vpage_xlate.sv
// Top of the paged translator: joins the associative cache and the sequencer.
// Assumes one request in flight; the flush should be pulsed on address space change.
module vpage_xlate #(
    parameter int VA_W      = 32,
    parameter int PAGE_BITS = 12,
    parameter int ENTRIES   = 64,
    localparam int VPN_W    = VA_W - PAGE_BITS
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [VA_W-1:0] req_vaddr,
    input  logic            req_write,
    input  logic            kern_mode,
    input  logic [VA_W-1:0] user_base,
    input  logic [VA_W-1:0] kern_base,
    input  logic            flush,
    output logic            mem_rd_en,
    output logic [VA_W-1:0] mem_rd_addr,
    input  logic            mem_rd_valid,
    input  logic [VA_W-1:0] mem_rd_data,
    output logic            resp_done,
    output logic            resp_fault,
    output logic [1:0]      resp_fault_code,
    output logic [VA_W-1:0] resp_paddr
);

    logic             hit;
    logic [VPN_W-1:0] hit_ppn;
    logic             hit_wr;
    logic             fill_en;
    logic [VPN_W-1:0] fill_vpn;
    logic [VPN_W-1:0] fill_ppn;
    logic             fill_wr;

    vpage_tcache #(
        .ENTRIES(ENTRIES),
        .VPN_W  (VPN_W),
        .PPN_W  (VPN_W)
    ) cache_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (flush),
        .lk_vpn  (req_vaddr[VA_W-1:PAGE_BITS]),
        .hit     (hit),
        .hit_ppn (hit_ppn),
        .hit_wr  (hit_wr),
        .fill_en (fill_en),
        .fill_vpn(fill_vpn),
        .fill_ppn(fill_ppn),
        .fill_wr (fill_wr)
    );

    vpage_ctrl #(
        .VA_W     (VA_W),
        .PAGE_BITS(PAGE_BITS)
    ) ctrl_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_valid      (req_valid),
        .req_vaddr      (req_vaddr),
        .req_write      (req_write),
        .kern_mode      (kern_mode),
        .user_base      (user_base),
        .kern_base      (kern_base),
        .hit            (hit),
        .hit_ppn        (hit_ppn),
        .hit_wr         (hit_wr),
        .fill_en        (fill_en),
        .fill_vpn       (fill_vpn),
        .fill_ppn       (fill_ppn),
        .fill_wr        (fill_wr),
        .mem_rd_en      (mem_rd_en),
        .mem_rd_addr    (mem_rd_addr),
        .mem_rd_valid   (mem_rd_valid),
        .mem_rd_data    (mem_rd_data),
        .resp_done      (resp_done),
        .resp_fault     (resp_fault),
        .resp_fault_code(resp_fault_code),
        .resp_paddr     (resp_paddr)
    );

    p_reset_quiet_r9: assert property (@(posedge clk)
        !rst_n |=> !(resp_done || resp_fault || mem_rd_en));

endmodule

// File: tb/vpage_xlate_tb_top.sv
`timescale 1ns/1ps
module vpage_xlate_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic        kern_mode = 1'b0;
    logic [31:0] user_base = 32'h0010_0000;
    logic [31:0] kern_base = 32'hFFE0_0000;
    logic        flush = 1'b0;
    logic        mem_rd_en;
    logic [31:0] mem_rd_addr;
    logic        mem_rd_valid = 1'b0;
    logic [31:0] mem_rd_data = '0;
    logic        resp_done;
    logic        resp_fault;
    logic [1:0]  resp_fault_code;
    logic [31:0] resp_paddr;

    int unsigned n_chk = 0;
    int unsigned n_bad = 0;
    int unsigned n_reads = 0;
    logic [31:0] last_addr = '0;
    bit          mem_pend = 1'b0;
    int unsigned mem_cnt = 0;
    bit          finished = 1'b0;

    // Reference cache model
    logic [19:0] m_tag [64];
    logic [31:0] m_pte [64];
    bit          m_vld [64];
    int unsigned m_rr = 0;

    always #2.5 clk = ~clk;

    vpage_xlate dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .req_write(req_write), .kern_mode(kern_mode), .user_base(user_base),
        .kern_base(kern_base), .flush(flush), .mem_rd_en(mem_rd_en),
        .mem_rd_addr(mem_rd_addr), .mem_rd_valid(mem_rd_valid),
        .mem_rd_data(mem_rd_data), .resp_done(resp_done), .resp_fault(resp_fault),
        .resp_fault_code(resp_fault_code), .resp_paddr(resp_paddr)
    );

    // Page table content as a hash of the entry's byte address.
    function automatic logic [31:0] pte_at(input logic [31:0] a);
        logic [31:0] h;
        h = a * 32'h9E37_79B1;
        h = h ^ (h >> 15);
        h = h * 32'h85EB_CA6B;
        h = h ^ (h >> 13);
        return {h[31:12], 10'b0, h[4], (h[3:0] != 4'h0)};
    endfunction

    function automatic logic [31:0] ent_addr(input logic [31:0] base, input logic [19:0] vpn);
        return base + {10'b0, vpn, 2'b00};
    endfunction

    // First page number from start whose entry has the wanted present/writable bits.
    function automatic logic [19:0] find_vpn(input logic [31:0] base, input logic [19:0] start,
                                             input bit want_p, input bit want_w);
        for (int k = 0; k < 4096; k++) begin
            logic [31:0] e;
            e = pte_at(ent_addr(base, start + 20'(k)));
            if (e[0] == want_p && (!want_p || e[1] == want_w)) return start + 20'(k);
        end
        return start;
    endfunction

    // Memory responder: answers 1..3 cycles after the strobe.
    always @(negedge clk) begin
        mem_rd_valid <= 1'b0;
        if (mem_pend) begin
            if (mem_cnt == 0) begin
                mem_rd_valid <= 1'b1;
                mem_rd_data  <= pte_at(last_addr);
                mem_pend = 1'b0;
            end else begin
                mem_cnt--;
            end
        end
        if (rst_n && mem_rd_en && !mem_pend) begin
            n_reads++;
            last_addr = mem_rd_addr;
            mem_pend  = 1'b1;
            mem_cnt   = $urandom % 3;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic int m_find(input logic [19:0] vpn);
        for (int i = 0; i < 64; i++) if (m_vld[i] && m_tag[i] == vpn) return i;
        return -1;
    endfunction

    task automatic m_install(input logic [19:0] vpn, input logic [31:0] e);
        int s;
        s = -1;
        for (int i = 63; i >= 0; i--) if (!m_vld[i]) s = i;
        if (s < 0) begin
            s = int'(m_rr);
            m_rr = (m_rr + 1) % 64;
        end
        m_vld[s] = 1'b1;
        m_tag[s] = vpn;
        m_pte[s] = e;
    endtask

    task automatic do_flush();
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        for (int i = 0; i < 64; i++) m_vld[i] = 1'b0;
    endtask

    task automatic set_mode(input bit k);
        kern_mode = k;
        do_flush();
    endtask

    // One translation; checks path, outcome and pulse width. obs_hit reports no-read.
    task automatic do_req(input logic [31:0] va, input bit wr, output bit obs_hit);
        logic [31:0] base, ea, e;
        int          s, cyc;
        int unsigned r0;
        bit          m_hit;
        base  = kern_mode ? kern_base : user_base;
        ea    = ent_addr(base, va[31:12]);
        s     = m_find(va[31:12]);
        m_hit = (s >= 0);
        e     = m_hit ? m_pte[s] : pte_at(ea);
        r0    = n_reads;
        @(negedge clk);
        req_valid = 1'b1;
        req_vaddr = va;
        req_write = wr;
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
        end while (!(resp_done || resp_fault) && cyc < 60);
        req_valid = 1'b0;
        obs_hit = (n_reads == r0);
        if (cyc >= 60) begin
            chk(1'b0, "R8", "no response", 32'(cyc), 32'd0);
        end else begin
            if (m_hit)
                chk(obs_hit && cyc == 1, "R2", "hit latency/no read", 32'(cyc), 32'd1);
            else
                chk(n_reads == r0 + 1 && last_addr == ea, "R3", "fetch address", last_addr, ea);
            if (!e[0])
                chk(resp_fault && !resp_done && resp_fault_code == 2'b01, "R4", "absent fault",
                    {30'b0, resp_fault_code}, 32'd1);
            else if (wr && !e[1])
                chk(resp_fault && !resp_done && resp_fault_code == 2'b10, "R5", "write-protect fault",
                    {30'b0, resp_fault_code}, 32'd2);
            else
                chk(resp_done && !resp_fault && resp_paddr == {e[31:12], va[11:0]}, "R1", "paddr",
                    resp_paddr, {e[31:12], va[11:0]});
        end
        if (!m_hit && e[0]) m_install(va[31:12], e);
        @(negedge clk);
        chk(!resp_done && !resp_fault, "R8", "response pulse width",
            {30'b0, resp_done, resp_fault}, 32'd0);
    endtask

    // Watchdog: counts as a failure and still prints the summary.
    initial begin
        #(150000 * 5);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        bit          h;
        logic [19:0] va_, vr_, vi_;
        logic [19:0] fill_v [65];
        void'($urandom(32'd2024));
        for (int i = 0; i < 64; i++) m_vld[i] = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: quiet after reset
        chk(!resp_done && !resp_fault && !mem_rd_en && resp_fault_code == 2'b00, "R9",
            "outputs after reset", {28'b0, resp_done, resp_fault, resp_fault_code}, 32'd0);

        // R3/R1/R2: first touch misses, repeat hits (user table)
        va_ = find_vpn(user_base, 20'h00010, 1'b1, 1'b1);
        do_req({va_, 12'hABC}, 1'b0, h);
        chk(!h, "R9", "empty cache after reset misses", 32'(h), 32'd0);
        do_req({va_, 12'h123}, 1'b1, h);
        chk(h, "R2", "repeat hits", 32'(h), 32'd1);

        // R5: read-only page, write on miss then read and write on hit
        vr_ = find_vpn(user_base, 20'h00200, 1'b1, 1'b0);
        do_req({vr_, 12'h004}, 1'b1, h);
        do_req({vr_, 12'h008}, 1'b0, h);
        chk(h, "R5", "read-only entry cached after fault", 32'(h), 32'd1);
        do_req({vr_, 12'h00C}, 1'b1, h);

        // R4: absent entry is never cached
        vi_ = find_vpn(user_base, 20'h00300, 1'b0, 1'b0);
        do_req({vi_, 12'h000}, 1'b0, h);
        do_req({vi_, 12'h000}, 1'b0, h);
        chk(!h, "R4", "absent entry misses again", 32'(h), 32'd0);

        // R6: flush makes a cached page miss
        do_flush();
        do_req({va_, 12'hFFF}, 1'b0, h);
        chk(!h, "R6", "miss after flush", 32'(h), 32'd0);

        // R3: kernel base selected by mode
        set_mode(1'b1);
        do_req({va_, 12'h010}, 1'b0, h);

        // R7: fill 65 present pages; slot 0 is replaced first
        do_flush();
        fill_v[0] = find_vpn(kern_base, 20'h01000, 1'b1, 1'b1);
        for (int i = 1; i < 65; i++) fill_v[i] = find_vpn(kern_base, fill_v[i-1] + 20'd1, 1'b1, 1'b1);
        for (int i = 0; i < 65; i++) do_req({fill_v[i], 12'h000}, 1'b0, h);
        do_req({fill_v[1], 12'h000}, 1'b0, h);
        chk(h, "R7", "second fill survives", 32'(h), 32'd1);
        do_req({fill_v[0], 12'h000}, 1'b0, h);
        chk(!h, "R7", "first fill replaced", 32'(h), 32'd0);
        do_req({fill_v[2], 12'h000}, 1'b0, h);
        chk(h, "R7", "pointer moved to slot 1 only", 32'(h), 32'd1);

        // Random traffic over a pool larger than the cache
        for (int t = 0; t < 1500; t++) begin
            int unsigned r;
            r = $urandom % 100;
            if (r < 2) set_mode(~kern_mode);
            else if (r < 5) do_flush();
            do_req({20'h00400 + 20'($urandom % 80), 12'($urandom)}, bit'($urandom % 3 == 0), h);
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule